// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words, A and B, and reports one of three relations: A above B, A below B, or A equal to B. It is built from identical 4-bit slices. Inside each slice, bit 3 is the most significant. Each slice also takes three cascade inputs (greater, less, equal) that carry the verdict of the positions below its least significant bit. The cascade inputs only matter when the slice's own two nibbles are identical.

The parameter `NSLICES` sets how many slices are chained in series inside the top-level wrapper. The buses are `4*NSLICES` bits wide. The lowest slice takes the top-level cascade inputs. Each slice's three outputs feed the cascade inputs of the next more significant slice, and the last slice's outputs are the result.

For a plain wide comparison, tie the cascade inputs to greater=0, less=0, equal=1. The block applies no decoding, so binary, BCD or any other monotonic code compares correctly. The design is purely combinational, and its outputs follow its inputs without a clock.

Top module: `magcmp_chain`

## Requirements
- R1: Within a slice, the highest bit position at which A and B differ decides the verdict, and the cascade inputs then have no effect on the outputs.
- R2: If A is above B at the deciding position, the outputs are gt=1, lt=0, eq=0. If A is below B there, they are gt=0, lt=1, eq=0.
- R3: If the nibbles are equal and cascade eq is 1, the outputs are gt=0, lt=0, eq=1, whatever the cascade gt and lt inputs are.
- R4: If the nibbles are equal, cascade eq is 0, and exactly one of cascade gt or lt is 1, that relation is passed through: (1,0,0) gives 1,0,0 and (0,1,0) gives 0,1,0.
- R5: If the nibbles are equal, cascade eq is 0, and cascade gt and lt are both 1, all three outputs are 0.
- R6: If the nibbles are equal and all three cascade inputs are 0, the outputs are gt=1, lt=1, eq=0.
- R7: The slices form a series chain. Slice k compares bits [4k+3:4k]. Slice 0 takes the top-level cascade inputs, and each slice's outputs drive the cascade inputs of slice k+1. With cascade inputs tied to gt=0, lt=0, eq=1, the outputs equal the unsigned relation of the full-width buses.
- R8: No code is decoded. Nibble values 10 to 15, which are not valid BCD digits, are ordered as plain unsigned numbers.
- R9: The block has no clock or state. The outputs reflect the present inputs with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 4*NSLICES | First operand, MSB at top |
| b_word | input | 4*NSLICES | Second operand, MSB at top |
| casc_gt_i | input | 1 | Cascade greater, from lower positions |
| casc_lt_i | input | 1 | Cascade less, from lower positions |
| casc_eq_i | input | 1 | Cascade equal, from lower positions |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B |

## Verification
Whenever the inputs change, the bound checker confirms three things at the top ports:

- Unequal words give the matching single-hot verdict.
- A cascade equal input survives an equal comparison.
- A single-hot cascade verdict is carried through unchanged.

For a one-slice chain, the checker also covers the two non-exclusive outcomes. The bench's scenarios alone show the rest:

- The full truth table of one slice, including which bit position wins.
- The behaviour of nibble values beyond BCD.
- Agreement of a four-slice chain with a reference unsigned comparison over random and edge-case words.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_res_t;

    typedef enum logic [1:0] {
        ORD_SAME  = 2'b00,
        ORD_ABOVE = 2'b01,
        ORD_BELOW = 2'b10
    } ord_t;

    // Verdict when the local nibbles tie: defer to lower positions.
    function automatic cmp_res_t resolve_tie(input cmp_res_t cin);
        cmp_res_t r;
        r.eq = cin.eq;
        r.gt = !cin.eq && !cin.lt;
        r.lt = !cin.eq && !cin.gt;
        return r;
    endfunction

    function automatic cmp_res_t from_order(input ord_t o);
        cmp_res_t r;
        r.gt = (o == ORD_ABOVE);
        r.lt = (o == ORD_BELOW);
        r.eq = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/magcmp_order.sv
module magcmp_order
    import magcmp_pkg::*;
(
    input  nib_t a_nib,
    input  nib_t b_nib,
    output ord_t order
);
    localparam int W = SLICE_W;

    logic [W:0]   same_above;
    logic [W-1:0] above_hit;
    logic [W-1:0] below_hit;

    assign same_above[W] = 1'b1;

    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign same_above[i] = same_above[i+1] & ~(a_nib[i] ^ b_nib[i]);
        assign above_hit[i]  = same_above[i+1] &  a_nib[i] & ~b_nib[i];
        assign below_hit[i]  = same_above[i+1] & ~a_nib[i] &  b_nib[i];
    end

    always_comb begin
        if (|above_hit)      order = ORD_ABOVE;
        else if (|below_hit) order = ORD_BELOW;
        else                 order = ORD_SAME;
    end

endmodule

// File: rtl/magcmp_merge.sv
module magcmp_merge
    import magcmp_pkg::*;
(
    input  ord_t     order,
    input  cmp_res_t cin,
    output cmp_res_t res
);
    always_comb begin
        if (order == ORD_SAME) res = resolve_tie(cin);
        else                   res = from_order(order);
    end
endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
    import magcmp_pkg::*;
(
    input  nib_t     a_nib,
    input  nib_t     b_nib,
    input  cmp_res_t cin,
    output cmp_res_t res
);
    ord_t order;

    magcmp_order u_order (
        .a_nib (a_nib),
        .b_nib (b_nib),
        .order (order)
    );

    magcmp_merge u_merge (
        .order (order),
        .cin   (cin),
        .res   (res)
    );
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int NSLICES = 4
) (
    input  logic [SLICE_W*NSLICES-1:0] a_word,
    input  logic [SLICE_W*NSLICES-1:0] b_word,
    input  logic                       casc_gt_i,
    input  logic                       casc_lt_i,
    input  logic                       casc_eq_i,
    output logic                       gt_o,
    output logic                       lt_o,
    output logic                       eq_o
);
    localparam int TOTAL_W = SLICE_W * NSLICES;

    cmp_res_t seed;
    assign seed = '{gt: casc_gt_i, lt: casc_lt_i, eq: casc_eq_i};

    for (genvar s = 0; s < NSLICES; s++) begin : g_stage
        cmp_res_t link_in;
        cmp_res_t link_out;

        if (s == 0) begin : g_first
            assign link_in = seed;
        end else begin : g_next
            assign link_in = g_stage[s-1].link_out;
        end

        magcmp_slice u_slice (
            .a_nib (a_word[s*SLICE_W +: SLICE_W]),
            .b_nib (b_word[s*SLICE_W +: SLICE_W]),
            .cin   (link_in),
            .res   (link_out)
        );
    end

    assign gt_o = g_stage[NSLICES-1].link_out.gt;
    assign lt_o = g_stage[NSLICES-1].link_out.lt;
    assign eq_o = g_stage[NSLICES-1].link_out.eq;

    if (TOTAL_W < SLICE_W) begin : g_bad_param
        initial $error("magcmp_chain: NSLICES must be at least 1");
    end
endmodule

// File: rtl/magcmp_chain_chk.sv
module magcmp_chain_chk #(
    parameter int NSLICES = 4
) (
    input logic [4*NSLICES-1:0] a_word,
    input logic [4*NSLICES-1:0] b_word,
    input logic                 casc_gt_i,
    input logic                 casc_lt_i,
    input logic                 casc_eq_i,
    input logic                 gt_o,
    input logic                 lt_o,
    input logic                 eq_o
);
    always_comb begin
        if (a_word > b_word)
            AST_ABOVE_WINS: assert ({gt_o, lt_o, eq_o} == 3'b100); // R2
        if (a_word < b_word)
            AST_BELOW_WINS: assert ({gt_o, lt_o, eq_o} == 3'b010); // R2
        if (a_word == b_word && casc_eq_i)
            AST_EQ_CARRIED: assert ({gt_o, lt_o, eq_o} == 3'b001); // R3
        if (a_word == b_word && !casc_eq_i && (casc_gt_i ^ casc_lt_i))
            AST_ONEHOT_CARRIED: assert ({gt_o, lt_o, eq_o} == {casc_gt_i, casc_lt_i, 1'b0}); // R4
    end

    if (NSLICES == 1) begin : g_single
        always_comb begin
            if (a_word == b_word && !casc_eq_i && casc_gt_i && casc_lt_i)
                AST_BOTH_HIGH_CLEARS: assert ({gt_o, lt_o, eq_o} == 3'b000); // R5
            if (a_word == b_word && !casc_eq_i && !casc_gt_i && !casc_lt_i)
                AST_ALL_LOW_SETS: assert ({gt_o, lt_o, eq_o} == 3'b110); // R6
        end
    end
endmodule

bind magcmp_chain magcmp_chain_chk #(.NSLICES(NSLICES)) u_chk (
    .a_word    (a_word),
    .b_word    (b_word),
    .casc_gt_i (casc_gt_i),
    .casc_lt_i (casc_lt_i),
    .casc_eq_i (casc_eq_i),
    .gt_o      (gt_o),
    .lt_o      (lt_o),
    .eq_o      (eq_o)
);

// File: tb/magcmp_chain_tb.sv
module magcmp_chain_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIDE_N     = 4;
    localparam int WIDE_W     = 4 * WIDE_N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // one-slice instance
    logic [3:0] a1, b1;
    logic cg, cl, ce;
    logic gt1, lt1, eq1;

    magcmp_chain #(.NSLICES(1)) u_dut (
        .a_word(a1), .b_word(b1),
        .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
        .gt_o(gt1), .lt_o(lt1), .eq_o(eq1)
    );

    // four-slice instance, legal tie-off
    logic [WIDE_W-1:0] aw, bw;
    logic gtw, ltw, eqw;

    magcmp_chain #(.NSLICES(WIDE_N)) u_wide (
        .a_word(aw), .b_word(bw),
        .casc_gt_i(1'b0), .casc_lt_i(1'b0), .casc_eq_i(1'b1),
        .gt_o(gtw), .lt_o(ltw), .eq_o(eqw)
    );

    task automatic check3(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got gt,lt,eq=%b expected %b", req, got, exp);
        end
    endtask

    // Reference verdict for one slice, from the requirements.
    function automatic logic [2:0] ref_slice(input logic [3:0] a, input logic [3:0] b,
                                            input logic g, input logic l, input logic e);
        if (a > b) return 3'b100;
        if (a < b) return 3'b010;
        case ({g, l, e})
            3'b100:  return 3'b100;
            3'b010:  return 3'b010;
            3'b110:  return 3'b000;
            3'b000:  return 3'b110;
            default: return 3'b001;
        endcase
    endfunction

    task automatic t_reset_state();
        a1 = 4'd0; b1 = 4'd0; cg = 0; cl = 0; ce = 1;
        aw = '0; bw = '0;
        #1;
        check3("R9 idle tie-off", {gt1, lt1, eq1}, 3'b001);
        check3("R7 idle wide", {gtw, ltw, eqw}, 3'b001);
    endtask

    task automatic t_truth_table();
        for (int v = 0; v < 2048; v++) begin
            a1 = v[3:0]; b1 = v[7:4]; {cg, cl, ce} = v[10:8];
            #1;
            if (a1 != b1)
                check3("R1 R2 unequal", {gt1, lt1, eq1}, ref_slice(a1, b1, cg, cl, ce));
            else if (ce)
                check3("R3 tie eq", {gt1, lt1, eq1}, ref_slice(a1, b1, cg, cl, ce));
            else if (cg ^ cl)
                check3("R4 tie onehot", {gt1, lt1, eq1}, ref_slice(a1, b1, cg, cl, ce));
            else if (cg)
                check3("R5 tie both", {gt1, lt1, eq1}, ref_slice(a1, b1, cg, cl, ce));
            else
                check3("R6 tie none", {gt1, lt1, eq1}, ref_slice(a1, b1, cg, cl, ce));
        end
    endtask

    task automatic t_msb_priority();
        // MSB favours A, lower bits favour B; cascade ignored
        a1 = 4'b1000; b1 = 4'b0111; cg = 0; cl = 1; ce = 0; #1;
        check3("R1 msb wins", {gt1, lt1, eq1}, 3'b100);
        a1 = 4'b0101; b1 = 4'b0110; cg = 1; cl = 0; ce = 1; #1;
        check3("R1 bit1 wins", {gt1, lt1, eq1}, 3'b010);
    endtask

    task automatic t_non_bcd();
        a1 = 4'd15; b1 = 4'd10; cg = 0; cl = 0; ce = 1; #1;
        check3("R8 15 vs 10", {gt1, lt1, eq1}, 3'b100);
        a1 = 4'd9; b1 = 4'd12; #1;
        check3("R8 9 vs 12", {gt1, lt1, eq1}, 3'b010);
    endtask

    task automatic t_wide_edges();
        aw = 16'h8000; bw = 16'h7FFF; #1;
        check3("R7 top slice decides", {gtw, ltw, eqw}, 3'b100);
        aw = 16'h1230; bw = 16'h1231; #1;
        check3("R7 low slice decides", {gtw, ltw, eqw}, 3'b010);
        aw = 16'hABCD; bw = 16'hABCD; #1;
        check3("R7 full equal", {gtw, ltw, eqw}, 3'b001);
        aw = 16'h0F00; bw = 16'h00FF; #1;
        check3("R7 middle slice decides", {gtw, ltw, eqw}, 3'b100);
    endtask

    task automatic t_wide_random();
        for (int k = 0; k < 1200; k++) begin
            aw = WIDE_W'($urandom);
            bw = (k % 4 == 0) ? aw ^ WIDE_W'(1 << (k % WIDE_W)) : WIDE_W'($urandom);
            if (k % 7 == 0) bw = aw;
            #1;
            check3("R7 random wide", {gtw, ltw, eqw},
                   {aw > bw, aw < bw, aw == bw});
        end
    endtask

    initial begin
        a1 = '0; b1 = '0; cg = 0; cl = 0; ce = 1; aw = '0; bw = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_msb_priority();
        t_non_bcd();
        t_truth_table();
        t_wide_edges();
        t_wide_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule